// File: doc/BRIEF.md
# Minimum-Time Reciprocal Counter

This block measures an input signal over a window that is at least a programmed number of system clocks long and always ends on a whole input period. The window opens on a qualifying leading edge of the A input. Periods, each running from a leading edge on A to a trailing edge on B, are counted for as long as a countdown loaded with the minimum time is still running. Once the countdown has expired, the next trailing edge closes the window and latches the accumulated value. A sub-mode selects what is accumulated: system clocks, clocks spent at the starting level of A, or the number of periods.

The resolution of the result follows the input frequency. A fast input fits many periods into the window, and a slow input is stretched to its next whole period, so software never has to choose a range. Three instances can share one input, one for each sub-mode. With the same minimum time and the same edge selection, they capture in the same clock. Dividing their results then gives the period and the duty cycle. The division itself is done outside the block.

The enable input acts as a synchronous reset when it is low. A done flag reports each capture and stays set until software acknowledges it.

Top module: `mintime_recip_ctr`

## Requirements
- R1: After rst_ni, done_o and result_o are 0. While en_i is low, done_o is cleared and any measurement in progress is abandoned.
- R2: While enabled, a window starts only on a qualifying leading edge of a_i. If a_i is already at its level when en_i rises, that does not count as an edge. The accumulator is 1 in the clock in which the window starts.
- R3: Let t0 be the clock in which the window starts. The window is captured on the first trailing edge at a clock t with t − t0 ≥ min_clks_i. A min_clks_i of 0 behaves as 1. The countdown reloads on every new window.
- R4: mode_i 0 (and 3) reports the number of system clocks from the starting clock to the capturing clock.
- R5: mode_i 1 reports how many clocks from the starting clock up to, but not including, the capturing clock sampled a_i at the level it had in the starting clock. With rising A edges this is the number of high clocks.
- R6: mode_i 2 reports the number of periods started in the window, the first one included.
- R7: edge_sel_i[1] selects the leading event on a_i: 0 is a rising edge, 1 is any change. edge_sel_i[0] selects the trailing event on b_i in the same way. An edge is a difference between two consecutive clock samples. A leading edge that arrives while a period is open is ignored.
- R8: If the capturing trailing edge coincides with a leading edge, the next window starts in the same clock with the accumulator at 1 and the countdown reloaded. Back-to-back windows then lose no clock.
- R9: A capture sets done_o and updates result_o in the same clock. done_o stays set until ack_i is high in a clock with no capture, and a capture wins over a simultaneous ack_i. result_o holds its value between captures.
- R10: If no trailing edge arrives, the block waits indefinitely and raises no done flag.
- R11: A captured result is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable. Low holds the block in reset, high runs it |
| a_i | input | 1 | Leading-edge input, synchronous to clk_i |
| b_i | input | 1 | Trailing-edge input, synchronous to clk_i |
| edge_sel_i | input | 2 | Bit 1: A any edge. Bit 0: B any edge |
| mode_i | input | 2 | Accumulated quantity: 0 clocks, 1 level clocks, 2 periods |
| min_clks_i | input | CNT_W | Minimum window length in system clocks |
| ack_i | input | 1 | Clears done_o |
| done_o | output | 1 | A result is ready |
| result_o | output | CNT_W | Last captured value |

## Verification
The assertions assume that a_i and b_i are already synchronous to clk_i. They also assume that mode_i, edge_sel_i and min_clks_i change only while en_i is low, and that no window lasts long enough to wrap the accumulator. The stimulus changes every input at the falling clock edge and reconfigures the block only during disabled gaps. Every window it produces is a few hundred clocks at most. The reference model follows the same assumptions: it checks the block's outputs against values computed from a fixed configuration per window.

// File: rtl/mtrc_pkg.sv
package mtrc_pkg;

  typedef enum logic [1:0] {
    ACC_CLOCKS  = 2'd0,
    ACC_LEVEL   = 2'd1,
    ACC_PERIODS = 2'd2
  } acc_mode_e;

  typedef enum logic [1:0] {
    MS_WAIT = 2'd0,
    MS_GAP  = 2'd1,
    MS_OPEN = 2'd2
  } meas_st_e;

endpackage

// File: rtl/mtrc_edge_det.sv
module mtrc_edge_det #(
  parameter int unsigned NUM = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] sig_i,
  input  logic [NUM-1:0] any_i,
  output logic [NUM-1:0] ev_o
);

  for (genvar g = 0; g < NUM; g++) begin : g_ch
    logic prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= sig_i[g];
    end

    assign ev_o[g] = any_i[g] ? (sig_i[g] ^ prev_q) : (sig_i[g] & ~prev_q);

    // R7: a rise-only event cannot repeat on the next clock
    a_r7_rise_not_twice: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!any_i[g] && ev_o[g]) |=> !(ev_o[g] && !any_i[g]));
  end

endmodule

// File: rtl/mtrc_min_timer.sv
module mtrc_min_timer #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] left_q;

  // holds limit-1 after load, so expiry is seen exactly limit clocks after start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              left_q <= '0;
    else if (clear_i)         left_q <= '0;
    else if (load_i)          left_q <= (limit_i == '0) ? '0 : limit_i - ONE;
    else if (left_q != '0)    left_q <= left_q - ONE;
  end

  assign expired_o = (left_q == '0);

  a_r3_stays_expired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && expired_o) |=> expired_o);

  a_r3_no_early_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i && limit_i > ONE) |=> !expired_o);

endmodule

// File: rtl/mtrc_accum.sv
module mtrc_accum
  import mtrc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         start_i,
  input  logic         run_i,
  input  acc_mode_e    mode_i,
  input  logic         hit_i,
  input  logic         period_i,
  output logic [W-1:0] acc_o
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] acc_q;
  logic         inc;

  always_comb begin
    unique case (mode_i)
      ACC_LEVEL:   inc = hit_i;
      ACC_PERIODS: inc = period_i;
      default:     inc = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (start_i) acc_q <= ONE;
    else if (run_i)   acc_q <= acc_q + {{(W-1){1'b0}}, inc};
  end

  assign acc_o = acc_q;

  a_r11_acc_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clear_i) |-> (acc_q != '0));

  a_r2_start_at_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !clear_i) |=> (acc_q == ONE));

endmodule

// File: rtl/mintime_recip_ctr.sv
module mintime_recip_ctr
  import mtrc_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             a_i,
  input  logic             b_i,
  input  logic [1:0]       edge_sel_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] min_clks_i,
  input  logic             ack_i,
  output logic             done_o,
  output logic [CNT_W-1:0] result_o
);

  localparam int unsigned NUM_IN = 2;

  logic [NUM_IN-1:0] ev;
  logic              lead, trail;
  meas_st_e          st_q, st_n;
  logic              start, cap, run, new_per, expired;
  logic              lvl_q, done_q;
  logic [CNT_W-1:0]  acc, result_q;

  mtrc_edge_det #(.NUM(NUM_IN)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i ({b_i, a_i}),
    .any_i ({edge_sel_i[0], edge_sel_i[1]}),
    .ev_o  (ev)
  );

  assign lead  = ev[0];
  assign trail = ev[1];

  always_comb begin
    st_n    = st_q;
    start   = 1'b0;
    cap     = 1'b0;
    run     = 1'b0;
    new_per = 1'b0;
    if (!en_i) begin
      st_n = MS_WAIT;
    end else begin
      unique case (st_q)
        MS_WAIT: if (lead) begin
          start = 1'b1;
          st_n  = MS_OPEN;
        end
        MS_GAP: begin
          run = 1'b1;
          if (lead) begin
            new_per = 1'b1;
            st_n    = MS_OPEN;
          end
        end
        MS_OPEN: begin
          run = 1'b1;
          if (trail && expired) begin
            cap = 1'b1;
            if (lead) start = 1'b1;   // contiguous restart
            else      st_n  = MS_WAIT;
          end else if (trail) begin
            if (lead) new_per = 1'b1;
            else      st_n    = MS_GAP;
          end
        end
        default: st_n = MS_WAIT;
      endcase
    end
  end

  mtrc_min_timer #(.W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (!en_i),
    .load_i   (start),
    .limit_i  (min_clks_i),
    .expired_o(expired)
  );

  mtrc_accum #(.W(CNT_W)) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!en_i),
    .start_i (start),
    .run_i   (run),
    .mode_i  (acc_mode_e'(mode_i)),
    .hit_i   (a_i == lvl_q),
    .period_i(new_per),
    .acc_o   (acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= MS_WAIT;
      lvl_q    <= 1'b0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      st_q <= st_n;
      if (start) lvl_q <= a_i;
      if (!en_i)      done_q <= 1'b0;
      else if (cap)   done_q <= 1'b1;
      else if (ack_i) done_q <= 1'b0;
      if (cap) result_q <= acc;
    end
  end

  assign done_o   = done_q;
  assign result_o = result_q;

  a_r1_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!done_o && st_q == MS_WAIT));

  a_r2_wait_for_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && st_q == MS_WAIT && !lead) |=> (st_q == MS_WAIT));

  a_r8_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cap && lead) |=> (st_q == MS_OPEN));

  a_r9_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && en_i && !ack_i) |=> done_o);

  a_r10_no_trail_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trail |=> $stable(result_o));

  a_r11_result_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o != '0));

endmodule

// File: tb/mintime_recip_ctr_bench.sv
module mintime_recip_ctr_bench;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0, en = 1'b0, a = 1'b0, b = 1'b0, ack = 1'b0;
  logic [1:0] esel = 2'd0, mode = 2'd0;
  logic [W-1:0] xlim = '0;
  logic done_m, done_h, done_p;
  logic [W-1:0] res_m, res_h, res_p;

  always #5 clk = ~clk;

  mintime_recip_ctr #(.CNT_W(W)) u_mintime_recip_ctr (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .a_i(a), .b_i(b), .edge_sel_i(esel),
    .mode_i(mode), .min_clks_i(xlim), .ack_i(ack), .done_o(done_m), .result_o(res_m));

  mintime_recip_ctr #(.CNT_W(W)) u_hi (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .a_i(a), .b_i(b), .edge_sel_i(esel),
    .mode_i(2'd1), .min_clks_i(xlim), .ack_i(ack), .done_o(done_h), .result_o(res_h));

  mintime_recip_ctr #(.CNT_W(W)) u_per (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .a_i(a), .b_i(b), .edge_sel_i(esel),
    .mode_i(2'd2), .min_clks_i(xlim), .ack_i(ack), .done_o(done_p), .result_o(res_p));

  int total = 0, bad = 0, cyc = 0;
  string req = "R1";

  // reference model state
  int m_st = 0, m_el = 0, m_hc = 0, m_pc = 0, m_res = 0;
  logic m_pa = 1'b0, m_pb = 1'b0, m_lvl = 1'b0, m_done = 1'b0, m_cap = 1'b0;

  // waveform generator
  int wp = 4, wh = 2, wb = -1, ph = 0;
  bit ratio_on = 0, unit_on = 0;
  int last_cap = -1;

  task automatic chk(bit ok, string r, longint act, longint exp, string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic start_win();
    m_el = 0; m_hc = 1; m_pc = 1; m_lvl = a; m_st = 2;
  endtask

  task automatic model_step();
    bit lead, trail;
    lead  = esel[1] ? (a != m_pa) : (a && !m_pa);
    trail = esel[0] ? (b != m_pb) : (b && !m_pb);
    m_cap = 1'b0;
    if (!en) begin
      m_st = 0; m_done = 1'b0;
    end else begin
      if (m_st != 0) m_el++;
      case (m_st)
        0: if (lead) start_win();
        1: begin
          if (a == m_lvl) m_hc++;
          if (lead) begin m_pc++; m_st = 2; end
        end
        default: begin
          if (trail && m_el >= int'(xlim)) begin
            m_cap = 1'b1;
            m_res = (mode == 2'd1) ? m_hc : (mode == 2'd2) ? m_pc : m_el;
            if (lead) start_win(); else m_st = 0;
          end else begin
            if (a == m_lvl) m_hc++;
            if (trail) begin
              if (lead) m_pc++; else m_st = 1;
            end
          end
        end
      endcase
      if (m_cap) m_done = 1'b1;
      else if (ack) m_done = 1'b0;
    end
    m_pa = a; m_pb = b;
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    cyc++;
    chk(done_m == m_done, req, longint'(done_m), longint'(m_done), "done_o");
    chk(res_m == W'(m_res), req, longint'(res_m), longint'(m_res), "result_o");
    if (m_cap) chk(res_m != '0, "R11", longint'(res_m), 1, "nonzero result");
  endtask

  task automatic wtick();
    a = (ph < wh);
    b = (wb == -1) ? (ph < wh) : (wb == -2) ? 1'b0 : (ph >= wb);
    ph = (ph + 1) % wp;
    tick();
    if (m_cap && ratio_on) begin
      if (last_cap >= 0)
        chk(int'(res_m) == cyc - last_cap, "R8", longint'(res_m), cyc - last_cap, "contiguous span");
      last_cap = cyc;
      chk(int'(res_m) >= int'(xlim) && int'(res_m) < int'(xlim) + wp, "R3",
          longint'(res_m), longint'(xlim), "window bounds");
      chk((int'(res_m) - int'(res_p) * wp) <= 1 && (int'(res_p) * wp - int'(res_m)) <= 1,
          "R4", longint'(res_m), longint'(res_p) * wp, "clocks per period");
      chk((int'(res_h) - int'(res_p) * wh) <= 1 && (int'(res_p) * wh - int'(res_h)) <= 1,
          "R5", longint'(res_h), longint'(res_p) * wh, "highs per period");
      chk(done_p && done_h, "R6", longint'(done_p), 1, "cells capture together");
    end
    if (m_cap && unit_on) chk(int'(res_m) == wp, "R3", longint'(res_m), wp, "zero limit single period");
  endtask

  task automatic set_wave(int p, int h, int bd);
    wp = p; wh = h; wb = bd; ph = 0;
  endtask

  task automatic off_gap();
    en = 1'b0;
    wtick();
    chk(done_m == 1'b0, "R1", longint'(done_m), 0, "disabled clears done");
    wtick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_m == 1'b0, "R1", longint'(done_m), 0, "reset done");
    chk(res_m == '0, "R1", longint'(res_m), 0, "reset result");

    // R4 with ratio and contiguity checks across three cells
    req = "R4"; mode = 2'd0; esel = 2'b00; xlim = 20; set_wave(7, 3, -1);
    ratio_on = 1; en = 1'b1;
    repeat (300) wtick();
    ratio_on = 0;
    off_gap();

    // R5 level counting, then R9 acknowledge
    req = "R5"; mode = 2'd1; xlim = 33; set_wave(10, 4, -1); en = 1'b1;
    repeat (250) wtick();
    chk(done_m == 1'b1, "R9", longint'(done_m), 1, "done held without ack");
    req = "R9"; ack = 1'b1;
    wtick();
    ack = 1'b0;
    if (!m_cap) chk(done_m == 1'b0, "R9", longint'(done_m), 0, "ack clears done");
    repeat (40) wtick();
    off_gap();

    // R6 period counting
    req = "R6"; mode = 2'd2; xlim = 50; set_wave(9, 5, -1); en = 1'b1;
    repeat (250) wtick();
    off_gap();

    // R3 zero limit acts as one clock
    req = "R3"; mode = 2'd0; xlim = 0; set_wave(6, 2, -1); unit_on = 1; en = 1'b1;
    repeat (60) wtick();
    unit_on = 0;
    off_gap();

    // R7 edge selections with a separate trailing input
    req = "R7"; mode = 2'd0; xlim = 15;
    for (int s = 1; s < 4; s++) begin
      esel = 2'(s); set_wave(8, 3, 5); en = 1'b1;
      repeat (150) wtick();
      off_gap();
    end

    // R10 trailing input never moves
    req = "R10"; esel = 2'b00; xlim = 5; set_wave(5, 2, -2); en = 1'b1;
    repeat (100) wtick();
    chk(done_m == 1'b0, "R10", longint'(done_m), 0, "no done without trailing edge");
    chk(int'(res_m) == m_res, "R10", longint'(res_m), m_res, "result unchanged");
    off_gap();

    // R2 input already high at enable
    req = "R2"; xlim = 4; a = 1'b1; b = 1'b1;
    tick();
    en = 1'b1;
    for (int i = 0; i < 10; i++) tick();
    chk(done_m == 1'b0, "R2", longint'(done_m), 0, "held level does not start");
    set_wave(6, 3, -1);
    repeat (60) wtick();
    chk(done_m == 1'b1, "R2", longint'(done_m), 1, "starts on later rise");
    off_gap();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule